// File: doc/BRIEF.md
# Serial Register Port Responder

This block is the peripheral end of a two-wire synchronous register port: a host-driven serial clock and one shared bidirectional data line. It oversamples both wires with a fast internal clock and collects an 8-bit command on rising serial-clock edges. The top bit of the command gives the direction and the lower seven bits select a register. For a read, the block returns the selected byte on the following eight falling edges, most significant bit first, and then releases the line.

The tri-state line is modelled as a data output plus an output enable. The surrounding logic fills the register file through a parallel write port. A command with the direction bit set is not acted on. Its eight following data bits are counted so that byte alignment is kept. A power-down input silences the port and restarts bit alignment.

Top module: `srp_slave`

## Requirements
- R1: After synchronous reset the output enable `sdio_oe` is low and the next serial bit is treated as bit 7 of a new command.
- R2: The command is shifted in MSB first on rising edges of `sclk_in`. Command bit 7 equal to 0 selects a read, and command bits 6..0 are the register address.
- R3: For a read, the first falling `sclk_in` edge after the eighth command bit drives D7. Each later falling edge drives the next lower bit, down to D0. The byte equals the register content, and the output does not change between falling edges.
- R4: `sdio_oe` stays low while the command byte is received, including after the eighth rising edge, until the first data falling edge.
- R5: D0 is held with `sdio_oe` high until the next falling `sclk_in` edge. That edge releases the line and also starts the next command, so reads can follow each other with no idle gap.
- R6: While `pwr_down` is high, `sdio_oe` is low from the next clock and `sclk_in` edges have no effect. After `pwr_down` falls, the next bit starts a new command, whatever partial transfer was in progress.
- R7: The read byte is captured when the eighth command bit is sampled. A parallel write to that register after this point does not change the byte being sent.
- R8: A command with bit 7 equal to 1 never drives the line. The eight rising edges that follow it are consumed, and the next rising edge is bit 7 of a new command.
- R9: A clock with `wr_en` high stores `wr_data` at `wr_addr` when the address is below `REG_DEPTH` (16 by default). Other addresses are ignored, and a read of them returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power-down: port idle, line released, alignment cleared |
| sclk_in | input | 1 | Serial clock from the host (asynchronous) |
| sdio_in | input | 1 | Value present on the shared data line |
| sdio_out | output | 1 | Data bit this block drives onto the line |
| sdio_oe | output | 1 | Drive enable for the data line (low = high impedance) |
| wr_en | input | 1 | Parallel register write strobe |
| wr_addr | input | 7 | Parallel write address |
| wr_data | input | 8 | Parallel write data |

## Verification
A serial-clock edge reaches the outputs on the third rising `clk` edge after the input changes: two synchroniser flops, then the registered output stage. The bench changes `sclk_in` on a falling `clk` edge, holds each serial half period for six clocks and samples at the end of it. Every data bit and enable value is therefore read three clocks after it settled. Parallel writes land one clock after the strobe, and power-down takes effect on the next clock. The bench waits at least two clocks before it checks either of them. Every address from 0 to 127 is read back to back against a computed pattern, which covers in-range and out-of-range registers.

// File: rtl/srp_pkg.sv
// Shared types for the serial register port responder.
package srp_pkg;
    // Transfer phase of the responder.
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,  // collecting command bits
        PH_SKIP = 2'd1,  // consuming data bits of a non-read command
        PH_DATA = 2'd2,  // driving read data on falling edges
        PH_HOLD = 2'd3   // holding the last bit until the next falling edge
    } srp_phase_t;
endpackage

// File: rtl/srp_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is sampled independently (no multi-bit coherence needed).
module srp_sync #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    // Two register stages toward the internal clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/srp_edge.sv
// Edge detector for the synchronised serial clock.
// Assumes the serial clock idles high, so the reset value does not produce a false edge.
module srp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic s,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= s;
    end

    assign rise = s & ~prev;
    assign fall = ~s & prev;
endmodule

// File: rtl/srp_regfile.sv
// Small register file: parallel write port, combinational read port.
// Addresses at or above DEPTH are not stored and read as zero.
module srp_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][DATA_W-1:0] rd_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DATA_W-1:0] q;
        // Store one entry when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))     q <= wr_data;
        end
        assign rd_vec[i] = q;
    end

    assign rd_data = (rd_addr < ADDR_W'(DEPTH)) ? rd_vec[rd_addr[IDX_W-1:0]] : '0;

    // Writes outside the file leave every entry unchanged.
    p_oor_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(DEPTH)) |=> $stable(rd_vec));
endmodule

// File: rtl/srp_ctrl.sv
// Transfer controller: shifts in the command on rising edges and shifts out
// read data on falling edges. Holds the last bit until the next falling edge.
// Assumes rise/fall are single-cycle pulses in the clk domain and that
// pwr_down is synchronous to clk.
module srp_ctrl
    import srp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int CMD_W = ADDR_W + 1;
    localparam int MAXB  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB);

    srp_phase_t        phase;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] cmd_sr;
    logic [DATA_W-1:0] tx_sr;
    logic              cmd_is_write;

    // The address is complete once the current bit is appended.
    assign rd_addr      = {cmd_sr[ADDR_W-2:0], sdi};
    assign cmd_is_write = cmd_sr[ADDR_W-1];

    // Phase sequencing, bit counting and the shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            phase  <= PH_CMD;
            cnt    <= '0;
            cmd_sr <= '0;
            tx_sr  <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else begin
            case (phase)
                PH_CMD: if (rise) begin
                    cmd_sr <= {cmd_sr[ADDR_W-2:0], sdi};
                    if (cnt == CNT_W'(CMD_W-1)) begin
                        cnt <= '0;
                        if (!cmd_is_write) begin
                            tx_sr <= rd_data;
                            phase <= PH_DATA;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SKIP: if (rise) begin
                    if (cnt == CNT_W'(DATA_W-1)) begin
                        cnt   <= '0;
                        phase <= PH_CMD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DATA: if (fall) begin
                    sdo_oe <= 1'b1;
                    sdo    <= tx_sr[DATA_W-1];
                    tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
                    if (cnt == CNT_W'(DATA_W-1)) begin
                        cnt   <= '0;
                        phase <= PH_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: if (fall) begin
                    sdo_oe <= 1'b0;
                    phase  <= PH_CMD;
                end
            endcase
        end
    end

    // Driving begins only on a detected falling edge.
    p_drive_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(fall));

    // Between falling edges the driven bit does not move.
    p_bit_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !fall && !pwr_down) |=> $stable(sdo));

    // The line is never driven while a command is being received.
    p_quiet_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD || phase == PH_SKIP) |-> !sdo_oe);

    // Release happens on a falling edge unless forced by power-down.
    p_release_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sdo_oe) && !$past(pwr_down)) |-> $past(fall));

    // Power-down silences the port on the next clock.
    p_pd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!sdo_oe && phase == PH_CMD && cnt == '0));
endmodule

// File: rtl/srp_slave.sv
// Serial register port responder top level.
// Assumes clk runs at least four times faster than sclk_in and that the
// host releases the data line after the eighth command bit.
module srp_slave #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int REG_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              sclk_in,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [1:0]        pins_s;
    logic              sclk_rise;
    logic              sclk_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    srp_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, sdio_in}),
        .q     (pins_s)
    );

    srp_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .s     (pins_s[1]),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    srp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(REG_DEPTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    srp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .rise     (sclk_rise),
        .fall     (sclk_fall),
        .sdi      (pins_s[0]),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sdo      (sdio_out),
        .sdo_oe   (sdio_oe)
    );
endmodule

// File: tb/test_srp_slave.sv
module test_srp_slave;
    localparam int H     = 6;     // clk cycles per serial half period
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sdio_in = 1'b0;
    logic       sdio_out;
    logic       sdio_oe;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    srp_slave i_srp_slave (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .sclk_in(sclk_in), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    function automatic logic [7:0] expect_rd(input int a);
        return (a < DEPTH) ? pat(a) : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic go_low(input logic b);
        sclk_in = 1'b0;
        sdio_in = b;
        repeat (H) @(negedge clk);
    endtask

    task automatic go_high();
        sclk_in = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic pwrite(input logic [6:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    // Full read. Checks release of the previous transfer (R5), quiet command
    // phase (R4), returned byte (R3) and D0 hold (R5).
    task automatic do_read(input logic [6:0] a, input logic [7:0] exp,
                           input bit poke, input logic [7:0] poke_val, input string tag);
        logic [7:0] cmd;
        logic [7:0] got;
        int early;
        int oe_miss;
        cmd = {1'b0, a};
        early = 0;
        oe_miss = 0;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            go_low(cmd[i]);
            if (i == 7) chk(!sdio_oe, "R5 release on next fall", int'(sdio_oe), 0);
            else if (sdio_oe) early++;
            go_high();
            if (sdio_oe) early++;
        end
        chk(early == 0, "R4 no drive in command", early, 0);
        if (poke) pwrite(a, poke_val);
        for (int j = 7; j >= 0; j--) begin
            go_low(1'b0);
            got[j] = sdio_out;
            if (!sdio_oe) oe_miss++;
            go_high();
        end
        chk(oe_miss == 0, "R3 drive during data", oe_miss, 0);
        chk(got == exp, tag, int'(got), int'(exp));
        chk(sdio_oe && sdio_out == exp[0], "R5 D0 held after last rise",
            int'({sdio_oe, sdio_out}), int'({1'b1, exp[0]}));
    endtask

    initial begin
        int drv;
        repeat (3) @(negedge clk);
        chk(!sdio_oe, "R1 reset oe", int'(sdio_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sdio_oe, "R1 idle after reset", int'(sdio_oe), 0);

        // R9: fill the file, plus one write outside it.
        for (int a = 0; a < DEPTH; a++) pwrite(7'(a), pat(a));
        pwrite(7'd100, 8'h3C);

        // R2 R3 R9: every address, back to back.
        for (int a = 0; a < 128; a++)
            do_read(7'(a), expect_rd(a), 1'b0, 8'h00, "R2 R3 R9 read byte");

        // R7: update the register after A0 is sampled.
        do_read(7'd3, pat(3), 1'b1, 8'h5A, "R7 byte latched at A0");
        do_read(7'd3, 8'h5A, 1'b0, 8'h00, "R7 new value on next read");

        // R8: write-direction command with a data byte, then a read.
        drv = 0;
        for (int i = 15; i >= 0; i--) begin
            logic [15:0] w;
            w = 16'h8AA5;
            go_low(w[i]);
            if (i == 15) chk(!sdio_oe, "R5 release before write cmd", int'(sdio_oe), 0);
            else if (sdio_oe) drv++;
            go_high();
            if (sdio_oe) drv++;
        end
        chk(drv == 0, "R8 write command never drives", drv, 0);
        do_read(7'd9, pat(9), 1'b0, 8'h00, "R8 alignment after write cmd");

        // R6: power-down in the middle of a command.
        for (int i = 7; i >= 4; i--) begin
            go_low(i[0]);
            go_high();
        end
        pwr_down = 1'b1;
        drv = 0;
        for (int k = 0; k < 5; k++) begin
            go_low(1'b1);
            if (sdio_oe) drv++;
            go_high();
            if (sdio_oe) drv++;
        end
        chk(drv == 0, "R6 quiet in power-down", drv, 0);
        pwr_down = 1'b0;
        repeat (2) @(negedge clk);
        do_read(7'd5, pat(5), 1'b0, 8'h00, "R6 realigned after power-down");

        // R6: power-down while data is being driven.
        for (int i = 7; i >= 0; i--) begin
            logic [7:0] c;
            c = 8'h0C;
            go_low(c[i]);
            go_high();
        end
        for (int j = 0; j < 3; j++) begin
            go_low(1'b0);
            go_high();
        end
        chk(sdio_oe, "R6 driving before power-down", int'(sdio_oe), 1);
        pwr_down = 1'b1;
        repeat (2) @(negedge clk);
        chk(!sdio_oe, "R6 release on power-down", int'(sdio_oe), 0);
        pwr_down = 1'b0;
        repeat (2) @(negedge clk);
        do_read(7'd14, pat(14), 1'b0, 8'h00, "R6 read after data-phase power-down");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule